// File: doc/BRIEF.md
# Glitch-Free Three-Source Clock Selector with Event Counter

This block takes three free-running clocks that have no phase relationship to one another. It places exactly one of them, or none, on a single output clock. Three select lines choose the source, and at most one of them is high at a time. Each source also supplies an active-low reset and a data-valid strobe. The block routes the reset and strobe of the chosen source to a 16-bit event counter. That counter runs on the output clock and counts the strobes of the active source.

A change of source never produces a short high or low phase on the output clock. Each source owns an enable flop clocked by its own clock, so the enable only moves while that clock is high. The output clock is the AND, over all sources, of (NOT enable OR source clock), so it rests high while no enable is set. On a switch, the old source drops its enable first. The new source raises its enable only after a two-flop synchronizer in its own domain has seen every other enable low. The no-source state in between holds the output high and keeps the counter in reset. The count therefore restarts from zero once the new source is running.

Top module: `clksel3_top`

## Requirements
- R1: While every source reset is asserted and no select is high, out_clk_o is 1, out_rst_n_o is 0, out_vld_o is 0 and evt_cnt_o is 0.
- R2: At most one source enable is set at any time.
- R3: No high or low phase of out_clk_o is shorter than half the period of the fastest source clock, including across changes of selection.
- R4: While no source is enabled, out_clk_o is 1, out_vld_o is 0 and out_rst_n_o is 0.
- R5: A source enable rises only on a rising edge of that source's clock, and only when every other enable was already low at the previous rising edge of that clock.
- R6: Once selection bit k (bit 0, 1 or 2 of src_sel_i) has settled, out_clk_o has the same period as src_clk_i[k].
- R7: out_vld_o and out_rst_n_o follow the enabled source only. Strobes on other sources do not reach out_vld_o or the count. Asserting the enabled source's reset drives out_rst_n_o low and clears the count.
- R8: The count rises by exactly one on each out_clk_o rising edge at which out_vld_o is high and the counter is out of reset.
- R9: The count is 16 bits wide and wraps from 65535 to 0.
- R10: After any change of source, the count starts again from 0.
- R11: When all select lines are low, the output settles in the no-source state and out_clk_o stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 3 | Source clocks; bit k is source k |
| src_rst_n_i | input | 3 | Active-low asynchronous reset per source |
| src_sel_i | input | 3 | Source select lines, at most one high |
| src_vld_i | input | 3 | Data-valid strobe per source, synchronous to its clock |
| out_clk_o | output | 1 | Selected clock, resting high when no source is enabled |
| out_rst_n_o | output | 1 | Reset of the enabled source, low when none is enabled |
| out_vld_o | output | 1 | Strobe of the enabled source, low when none is enabled |
| evt_cnt_o | output | 16 | Count of strobes seen on the selected clock |

## Verification
The assertions assume that the select lines stay one-hot or zero. They also assume a new selection is held until the previous handover is complete, so a source is never re-picked while another enable is still draining through the synchronizers. The bench changes a select only after several hundred nanoseconds of settling, which covers many periods of the slowest clock. Each strobe is driven on a falling edge of its own source clock, so the counter samples a stable level. A source reset is asserted only just after that source's rising edge, while its clock is high. This keeps the asynchronous enable clear from cutting a low phase short.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int unsigned SRC_N      = 3;
  localparam int unsigned CNT_WIDTH  = 16;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer with asynchronous clear. With d tied high it
// serves as a reset synchronizer: assert at once, release after STAGES edges.
module clksel_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clksel_src_gate.sv
`timescale 1ns/1ps
// Enable control for one source, living entirely in that source's clock domain.
module clksel_src_gate #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned IDX    = 0,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sel_i,
  input  logic [N_SRC-1:0] en_all_i,
  output logic             en_o,
  output logic             rst_n_s_o
);
  localparam logic [N_SRC-1:0] OWN_MASK = {{(N_SRC-1){1'b0}}, 1'b1} << IDX;
  localparam int unsigned      SYNC_W   = N_SRC + 1;

  logic             rst_s;
  logic             sel_s;
  logic [N_SRC-1:0] peer_s;
  logic [SYNC_W-1:0] sync_q;
  logic             en_d, en_q;

  clksel_sync #(.W(1), .STAGES(STAGES)) rst_sync_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (1'b1),
    .q_o    (rst_s)
  );

  clksel_sync #(.W(SYNC_W), .STAGES(STAGES)) ctl_sync_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_s),
    .d_i    ({sel_i, en_all_i}),
    .q_o    (sync_q)
  );

  assign sel_s  = sync_q[SYNC_W-1];
  assign peer_s = sync_q[N_SRC-1:0];

  // Break before make: enable only when every foreign enable is seen low.
  always_comb begin
    en_d = sel_s && ((peer_s & ~OWN_MASK) == '0);
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o      = en_q;
  assign rst_n_s_o = rst_s;
endmodule

// File: rtl/clksel_out_mux.sv
`timescale 1ns/1ps
// Output gating: each term is high unless its source is enabled and low.
module clksel_out_mux #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] clk_i,
  input  logic [N_SRC-1:0] vld_i,
  input  logic [N_SRC-1:0] rst_n_s_i,
  output logic             clk_o,
  output logic             vld_o,
  output logic             rst_n_o
);
  logic [N_SRC-1:0] clk_term;

  for (genvar g = 0; g < N_SRC; g++) begin : g_term
    assign clk_term[g] = ~en_i[g] | clk_i[g];
  end

  assign clk_o   = &clk_term;
  assign vld_o   = |(en_i & vld_i);
  assign rst_n_o = |(en_i & rst_n_s_i);
endmodule

// File: rtl/clksel_evt_counter.sv
`timescale 1ns/1ps
// Wrapping event counter on the selected clock with its own reset release.
module clksel_evt_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             vld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  logic             run_rst_n;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  clksel_sync #(.W(1), .STAGES(STAGES)) cnt_rst_sync_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .d_i    (1'b1),
    .q_o    (run_rst_n)
  );

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge run_rst_n) begin
    if (!run_rst_n)  cnt_q <= '0;
    else if (vld_i)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign run_o = run_rst_n;
endmodule

// File: rtl/clksel3_top.sv
`timescale 1ns/1ps
module clksel3_top #(
  parameter int unsigned N_SRC  = clksel_pkg::SRC_N,
  parameter int unsigned CNT_W  = clksel_pkg::CNT_WIDTH,
  parameter int unsigned STAGES = clksel_pkg::SYNC_DEPTH
) (
  input  logic [N_SRC-1:0] src_clk_i,
  input  logic [N_SRC-1:0] src_rst_n_i,
  input  logic [N_SRC-1:0] src_sel_i,
  input  logic [N_SRC-1:0] src_vld_i,
  output logic             out_clk_o,
  output logic             out_rst_n_o,
  output logic             out_vld_o,
  output logic [CNT_W-1:0] evt_cnt_o
);
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] src_rst_s;
  logic             cnt_run;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    clksel_src_gate #(.N_SRC(N_SRC), .IDX(g), .STAGES(STAGES)) gate_i (
      .clk_i    (src_clk_i[g]),
      .rst_n_i  (src_rst_n_i[g]),
      .sel_i    (src_sel_i[g]),
      .en_all_i (src_en),
      .en_o     (src_en[g]),
      .rst_n_s_o(src_rst_s[g])
    );
  end

  clksel_out_mux #(.N_SRC(N_SRC)) mux_i (
    .en_i     (src_en),
    .clk_i    (src_clk_i),
    .vld_i    (src_vld_i),
    .rst_n_s_i(src_rst_s),
    .clk_o    (out_clk_o),
    .vld_o    (out_vld_o),
    .rst_n_o  (out_rst_n_o)
  );

  clksel_evt_counter #(.CNT_W(CNT_W), .STAGES(STAGES)) cnt_i (
    .clk_i  (out_clk_o),
    .rst_n_i(out_rst_n_o),
    .vld_i  (out_vld_o),
    .cnt_o  (evt_cnt_o),
    .run_o  (cnt_run)
  );
endmodule

// File: rtl/clksel3_chk.sv
`timescale 1ns/1ps
module clksel3_chk #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic [N_SRC-1:0] src_clk,
  input logic [N_SRC-1:0] src_rst_n,
  input logic [N_SRC-1:0] en,
  input logic             out_clk,
  input logic             out_rst_n,
  input logic             out_vld,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_run
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    localparam logic [N_SRC-1:0] OWN = {{(N_SRC-1){1'b0}}, 1'b1} << g;

    p_single_en_r2: assert property (@(posedge src_clk[g])
      disable iff (!src_rst_n[g]) $onehot0(en));

    p_idle_high_r4: assert property (@(posedge src_clk[g])
      disable iff (!src_rst_n[g])
      (en == '0) |-> (out_clk && !out_vld && !out_rst_n));

    p_make_after_break_r5: assert property (@(posedge src_clk[g])
      disable iff (!src_rst_n[g])
      $rose(en[g]) |-> (($past(en) & ~OWN) == '0));
  end

  p_count_step_r8: assert property (@(posedge out_clk)
    disable iff (!cnt_run)
    1'b1 |=> (cnt == CNT_W'($past(cnt) + CNT_W'($past(out_vld)))));
endmodule

bind clksel3_top clksel3_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) chk_i (
  .src_clk  (src_clk_i),
  .src_rst_n(src_rst_n_i),
  .en       (src_en),
  .out_clk  (out_clk_o),
  .out_rst_n(out_rst_n_o),
  .out_vld  (out_vld_o),
  .cnt      (evt_cnt_o),
  .cnt_run  (cnt_run)
);

// File: tb/clksel3_top_tb_top.sv
`timescale 1ns/1ps
module clksel3_top_tb_top;
  localparam real PER0 = 5.0;   // 200 MHz
  localparam real PER1 = 7.0;
  localparam real PER2 = 12.0;
  localparam real MIN_PHASE = PER0 / 2.0;

  logic [2:0]  src_clk;
  logic [2:0]  src_rst_n;
  logic [2:0]  src_sel;
  logic [2:0]  src_vld;
  logic        out_clk, out_rst_n, out_vld;
  logic [15:0] evt_cnt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  clksel3_top dut_i (
    .src_clk_i  (src_clk),
    .src_rst_n_i(src_rst_n),
    .src_sel_i  (src_sel),
    .src_vld_i  (src_vld),
    .out_clk_o  (out_clk),
    .out_rst_n_o(out_rst_n),
    .out_vld_o  (out_vld),
    .evt_cnt_o  (evt_cnt)
  );

  initial begin src_clk[0] = 1'b0; forever #(PER0/2.0) src_clk[0] = ~src_clk[0]; end
  initial begin src_clk[1] = 1'b0; #1.3; forever #(PER1/2.0) src_clk[1] = ~src_clk[1]; end
  initial begin src_clk[2] = 1'b0; #2.1; forever #(PER2/2.0) src_clk[2] = ~src_clk[2]; end

  // Phase-width monitor on the output clock
  bit  mon_on = 0;
  bit  mon_first = 1;
  real t_last = 0.0;
  real min_hi = 1.0e9;
  real min_lo = 1.0e9;
  always @(out_clk) begin
    if (mon_on) begin
      if (!mon_first) begin
        if (out_clk == 1'b0) begin
          if ($realtime - t_last < min_hi) min_hi = $realtime - t_last;
        end else begin
          if ($realtime - t_last < min_lo) min_lo = $realtime - t_last;
        end
      end
      mon_first = 0;
      t_last = $realtime;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int s);
    case (s)
      0:       @(negedge src_clk[0]);
      1:       @(negedge src_clk[1]);
      default: @(negedge src_clk[2]);
    endcase
  endtask

  task automatic wait_pos(input int s);
    case (s)
      0:       @(posedge src_clk[0]);
      1:       @(posedge src_clk[1]);
      default: @(posedge src_clk[2]);
    endcase
  endtask

  function automatic real per_of(input int s);
    return (s == 0) ? PER0 : (s == 1) ? PER1 : PER2;
  endfunction

  task automatic pulses(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      wait_neg(s); src_vld[s] = 1'b1;
      wait_neg(s); src_vld[s] = 1'b0;
      wait_neg(s);
    end
  endtask

  task automatic t_reset_state;
    #20;
    chk(out_clk == 1'b1, "R1", "out_clk in reset", out_clk, 1);
    chk(out_rst_n == 1'b0, "R1", "out_rst_n in reset", out_rst_n, 0);
    chk(out_vld == 1'b0, "R1", "out_vld in reset", out_vld, 0);
    chk(evt_cnt == 16'd0, "R1", "count in reset", evt_cnt, 0);
    src_rst_n = 3'b111;
    #200;
    mon_on = 1;
    chk(out_clk == 1'b1 && out_rst_n == 1'b0, "R4", "idle after reset release",
        {out_clk, out_rst_n}, 2);
  endtask

  // R6 R7 R10: switching to a source yields its period, its reset and a fresh count
  task automatic t_select(input int s);
    real t0, t1;
    src_sel = 3'b000;
    src_sel[s] = 1'b1;
    #600;
    chk(out_rst_n == 1'b1, "R7", "routed reset released", out_rst_n, 1);
    wait_neg(s);
    chk(evt_cnt == 16'd0, "R10", "count restarts after switch", evt_cnt, 0);
    @(posedge out_clk); t0 = $realtime;
    @(posedge out_clk); t1 = $realtime;
    chk((t1 - t0) > per_of(s) - 0.01 && (t1 - t0) < per_of(s) + 0.01, "R6",
        "output period in ps", longint'((t1 - t0) * 1000.0),
        longint'(per_of(s) * 1000.0));
  endtask

  task automatic t_count(input int s, input int n);
    logic [15:0] c0;
    wait_neg(s); c0 = evt_cnt;
    pulses(s, n);
    wait_neg(s);
    chk(evt_cnt == c0 + 16'(n), "R8", "count after strobes", evt_cnt, c0 + 16'(n));
  endtask

  task automatic t_foreign(input int s, input int other);
    logic [15:0] c0;
    bit          leak;
    leak = 0;
    wait_neg(s); c0 = evt_cnt;
    for (int k = 0; k < 4; k++) begin
      wait_neg(other); src_vld[other] = 1'b1;
      #0.5; if (out_vld) leak = 1;
      wait_neg(other); src_vld[other] = 1'b0;
    end
    repeat (4) wait_neg(s);
    chk(!leak, "R7", "foreign strobe on out_vld", leak, 0);
    chk(evt_cnt == c0, "R7", "count after foreign strobes", evt_cnt, c0);
  endtask

  task automatic t_src_reset(input int s);
    wait_pos(s); #0.5;
    src_rst_n[s] = 1'b0;
    #0.5;
    chk(out_rst_n == 1'b0, "R7", "source reset routed", out_rst_n, 0);
    chk(evt_cnt == 16'd0, "R7", "count cleared by source reset", evt_cnt, 0);
    #100;
    src_rst_n[s] = 1'b1;
    #600;
    chk(out_rst_n == 1'b1, "R7", "reset released again", out_rst_n, 1);
    wait_neg(s);
    chk(evt_cnt == 16'd0, "R10", "count zero after re-enable", evt_cnt, 0);
  endtask

  task automatic t_deselect;
    bit dropped;
    dropped = 0;
    src_sel = 3'b000;
    #600;
    for (int k = 0; k < 20; k++) begin
      #1.7; if (out_clk !== 1'b1) dropped = 1;
    end
    chk(!dropped, "R11", "out_clk held high with no select", dropped, 0);
    chk(out_rst_n == 1'b0 && out_vld == 1'b0, "R4", "idle reset and strobe",
        {out_rst_n, out_vld}, 0);
    chk(evt_cnt == 16'd0, "R4", "count held in reset", evt_cnt, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] c0;
    wait_neg(0); c0 = evt_cnt;
    src_vld[0] = 1'b1;
    repeat (65539) wait_neg(0);
    src_vld[0] = 1'b0;
    wait_neg(0);
    chk(evt_cnt == c0 + 16'd3, "R9", "count after wrap", evt_cnt, c0 + 16'd3);
  endtask

  initial begin
    src_rst_n = 3'b000;
    src_sel   = 3'b000;
    src_vld   = 3'b000;
    t_reset_state();
    t_select(0);
    t_count(0, 5);
    t_foreign(0, 2);
    t_select(1);
    t_count(1, 7);
    t_src_reset(1);
    t_count(1, 3);
    t_select(2);
    t_count(2, 4);
    t_foreign(2, 0);
    t_deselect();
    t_select(0);
    t_wrap();
    t_select(2);
    t_select(1);
    t_deselect();
    // R2 R3 R5: an overlap of enables or an early enable would show as a short phase
    chk(min_hi >= MIN_PHASE - 0.01, "R3", "shortest high phase in ps",
        longint'(min_hi * 1000.0), longint'(MIN_PHASE * 1000.0));
    chk(min_lo >= MIN_PHASE - 0.01, "R5", "shortest low phase in ps",
        longint'(min_lo * 1000.0), longint'(MIN_PHASE * 1000.0));
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * PER0);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule